// File: doc/BRIEF.md
# Colour Lookup Table with Indexed Host Access

This block holds a 256-entry colour table whose entries are three 6-bit components. A host reaches it through a small byte-wide register window chosen by a 2-bit select: a write pointer, a shared data port, a pixel mask and a read pointer. To program entries, the host loads the write pointer and then writes components to the data port, red first, then green, then blue. One counter that wraps after three steps tracks which component comes next. To read entries back, the host loads the read pointer and reads the data port. The same counter then steps through red, green and blue.

On the display side, each clock presents an 8-bit pixel code. The block ANDs this code with the mask register and looks up the resulting address. The three components of that entry appear one clock later.

Top module: `pal_lut_port`

Register select encoding: 0 selects the write pointer, 1 the data port, 2 the pixel mask, and 3 the read pointer. A host write acts when `host_wr` is high at a clock edge. A data-port read takes effect at the edge where `host_rd` is high, `host_wr` is low and select is 1. `host_rdata` always shows the selected register combinationally.

## Requirements
- R1: A data-port write stores bits 5:0 of the byte and drops bits 7:6. A data-port read returns the stored component on bits 5:0, with bits 7:6 at zero.
- R2: After the write pointer is loaded, data-port writes fill red, then green, then blue of the addressed entry.
- R3: Writing blue advances the write pointer by one, modulo 256. Reading select 0 returns the current write pointer, so N triplets from pointer P leave it at (P+N) mod 256.
- R4: After the read pointer is loaded, data-port reads return red, then green, then blue. The read pointer advances by one, modulo 256, after blue. Select 3 reads back the read pointer.
- R5: Loading either pointer returns the component counter to red, even in the middle of a triplet.
- R6: Red and green are held aside and reach the table only when blue is written. Until then, a lookup of that entry returns its previous contents.
- R7: The pixel code is ANDed with the mask register before lookup. The mask reads back the value written, and 0xFF leaves the code unchanged.
- R8: The pixel outputs show the entry for the code presented at one clock edge, starting at that edge, and hold it until the next edge.
- R9: After reset, both pointers read 0, the counter is at red, the staging registers are clear, and the mask reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_sel | input | 2 | Register select (0 write pointer, 1 data, 2 mask, 3 read pointer) |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (side effects on the data port only) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Selected register contents |
| pix_code | input | 8 | Pixel code for lookup |
| pix_red | output | 6 | Looked-up red, registered |
| pix_grn | output | 6 | Looked-up green, registered |
| pix_blu | output | 6 | Looked-up blue, registered |

## Verification
The bench programs triplets across the 255-to-0 boundary and reads them back across the same boundary. A design with a wrongly sized or unwrapped pointer would lose the entries near zero or report a wrong pointer. It restarts both a write and a read in the middle of a triplet. A counter that is not cleared by a pointer load would shift every component into the wrong colour. It looks up an entry after only red and green have been written. A design that commits each component as it arrives would show the new colour too early. It also checks that masked codes alias onto low entries, that the pixel outputs change exactly one edge after the code does, and that bits 7:6 never leak through the data port.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    C_RED = 2'd0,
    C_GRN = 2'd1,
    C_BLU = 2'd2
  } comp_e;

  typedef enum logic [1:0] {
    SEL_WIDX = 2'd0,
    SEL_DATA = 2'd1,
    SEL_MASK = 2'd2,
    SEL_RIDX = 2'd3
  } sel_e;
endpackage

// File: rtl/pal_seq.sv
module pal_seq #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_widx,
  input  logic                ld_ridx,
  input  logic                data_wr,
  input  logic                data_rd,
  input  logic [IDX_W-1:0]    idx_wdata,
  input  logic [COMP_W-1:0]   comp_wdata,
  output logic [IDX_W-1:0]    wr_idx,
  output logic [IDX_W-1:0]    rd_idx,
  output pal_pkg::comp_e      comp,
  output logic                commit,
  output logic [3*COMP_W-1:0] commit_rgb
);
  import pal_pkg::*;

  comp_e             comp_d;
  logic [IDX_W-1:0]  wr_idx_d, rd_idx_d;
  logic [COMP_W-1:0] stg_r, stg_g, stg_r_d, stg_g_d;
  logic              comp_en, stg_r_en, stg_g_en;

  assign commit     = data_wr && (comp == C_BLU);
  assign commit_rgb = {stg_r, stg_g, comp_wdata};

  always_comb begin
    comp_en = ld_widx || ld_ridx || data_wr || data_rd;
    comp_d  = comp;
    if (ld_widx || ld_ridx) begin
      comp_d = C_RED;
    end else if (data_wr || data_rd) begin
      case (comp)
        C_RED:   comp_d = C_GRN;
        C_GRN:   comp_d = C_BLU;
        default: comp_d = C_RED;
      endcase
    end
  end

  always_comb begin
    wr_idx_d = wr_idx;
    if (ld_widx) wr_idx_d = idx_wdata;
    else if (commit) wr_idx_d = wr_idx + 1'b1;
  end

  always_comb begin
    rd_idx_d = rd_idx;
    if (ld_ridx) rd_idx_d = idx_wdata;
    else if (data_rd && (comp == C_BLU)) rd_idx_d = rd_idx + 1'b1;
  end

  always_comb begin
    stg_r_en = data_wr && (comp == C_RED);
    stg_g_en = data_wr && (comp == C_GRN);
    stg_r_d  = comp_wdata;
    stg_g_d  = comp_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp   <= C_RED;
      wr_idx <= '0;
      rd_idx <= '0;
      stg_r  <= '0;
      stg_g  <= '0;
    end else begin
      if (comp_en)  comp   <= comp_d;
      wr_idx <= wr_idx_d;
      rd_idx <= rd_idx_d;
      if (stg_r_en) stg_r  <= stg_r_d;
      if (stg_g_en) stg_g  <= stg_g_d;
    end
  end

  // R2
  comp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comp != 2'd3);

  // R3
  wr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && comp == C_BLU) |=> wr_idx == $past(wr_idx) + 1'b1);

  // R4
  rd_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && comp == C_BLU) |=> rd_idx == $past(rd_idx) + 1'b1);

  // R5
  comp_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_widx || ld_ridx) |=> comp == C_RED);
endmodule

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                commit,
  input  logic [IDX_W-1:0]    commit_idx,
  input  logic [3*COMP_W-1:0] commit_rgb,
  input  logic [IDX_W-1:0]    host_idx,
  input  pal_pkg::comp_e      host_comp,
  output logic [COMP_W-1:0]   host_comp_q,
  input  logic [IDX_W-1:0]    pix_idx,
  output logic [3*COMP_W-1:0] pix_rgb
);
  import pal_pkg::*;
  localparam int DEPTH = 1 << IDX_W;

  logic [3*COMP_W-1:0] mem [DEPTH];
  logic [3*COMP_W-1:0] host_entry;
  logic [3*COMP_W-1:0] pix_d;

  always_ff @(posedge clk) begin
    if (commit) mem[commit_idx] <= commit_rgb;
  end

  always_comb begin
    host_entry = mem[host_idx];
    case (host_comp)
      C_RED:   host_comp_q = host_entry[3*COMP_W-1:2*COMP_W];
      C_GRN:   host_comp_q = host_entry[2*COMP_W-1:COMP_W];
      default: host_comp_q = host_entry[COMP_W-1:0];
    endcase
    pix_d = mem[pix_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_rgb <= '0;
    else        pix_rgb <= pix_d;
  end
endmodule

// File: rtl/pal_lut_port.sv
module pal_lut_port #(
  parameter int DATA_W = 8,
  parameter int COMP_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [DATA_W-1:0] pix_code,
  output logic [COMP_W-1:0] pix_red,
  output logic [COMP_W-1:0] pix_grn,
  output logic [COMP_W-1:0] pix_blu
);
  import pal_pkg::*;
  localparam int IDX_W = DATA_W;
  localparam int PAD_W = DATA_W - COMP_W;

  logic [1:0]          rst_sync;
  logic                rst_core_n;
  logic                ld_widx, ld_ridx, data_wr, data_rd, mask_en;
  logic [DATA_W-1:0]   mask_q;
  logic [IDX_W-1:0]    wr_idx, rd_idx;
  comp_e               comp;
  logic                commit;
  logic [3*COMP_W-1:0] commit_rgb, pix_rgb;
  logic [COMP_W-1:0]   host_comp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  always_comb begin
    ld_widx = host_wr && (host_sel == SEL_WIDX);
    ld_ridx = host_wr && (host_sel == SEL_RIDX);
    data_wr = host_wr && (host_sel == SEL_DATA);
    data_rd = host_rd && !host_wr && (host_sel == SEL_DATA);
    mask_en = host_wr && (host_sel == SEL_MASK);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) mask_q <= '1;
    else if (mask_en) mask_q <= host_wdata;
  end

  pal_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .ld_widx    (ld_widx),
    .ld_ridx    (ld_ridx),
    .data_wr    (data_wr),
    .data_rd    (data_rd),
    .idx_wdata  (host_wdata),
    .comp_wdata (host_wdata[COMP_W-1:0]),
    .wr_idx     (wr_idx),
    .rd_idx     (rd_idx),
    .comp       (comp),
    .commit     (commit),
    .commit_rgb (commit_rgb)
  );

  pal_ram #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_ram (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .commit      (commit),
    .commit_idx  (wr_idx),
    .commit_rgb  (commit_rgb),
    .host_idx    (rd_idx),
    .host_comp   (comp),
    .host_comp_q (host_comp_q),
    .pix_idx     (pix_code & mask_q),
    .pix_rgb     (pix_rgb)
  );

  assign pix_red = pix_rgb[3*COMP_W-1:2*COMP_W];
  assign pix_grn = pix_rgb[2*COMP_W-1:COMP_W];
  assign pix_blu = pix_rgb[COMP_W-1:0];

  always_comb begin
    case (host_sel)
      SEL_WIDX: host_rdata = wr_idx;
      SEL_DATA: host_rdata = {{PAD_W{1'b0}}, host_comp_q};
      SEL_MASK: host_rdata = mask_q;
      default:  host_rdata = rd_idx;
    endcase
  end

  // R1
  data_pad_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (host_sel == SEL_DATA) |-> host_rdata[DATA_W-1:COMP_W] == '0);

  // R7
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    mask_en |=> mask_q == $past(host_wdata));
endmodule

// File: tb/pal_lut_port_tb.sv
module pal_lut_port_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] host_sel;
  logic       host_wr, host_rd;
  logic [7:0] host_wdata, host_rdata, pix_code;
  logic [5:0] pix_red, pix_grn, pix_blu;
  int         errors = 0;
  int         checks = 0;
  logic [17:0] model [256];

  always #5 clk = ~clk;

  pal_lut_port u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pix_code(pix_code), .pix_red(pix_red), .pix_grn(pix_grn), .pix_blu(pix_blu)
  );

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [1:0] sel, input logic [7:0] d);
    host_sel = sel; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input logic [1:0] sel, output logic [7:0] d);
    host_sel = sel; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic put(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                     input logic [7:0] idx);
    hw(2'd1, r); hw(2'd1, g); hw(2'd1, b);
    model[idx] = {r[5:0], g[5:0], b[5:0]};
  endtask

  task automatic look(input logic [7:0] code, output logic [17:0] v);
    pix_code = code;
    @(negedge clk);
    v = {pix_red, pix_grn, pix_blu};
  endtask

  task automatic t_reset();
    logic [7:0] d;
    hr(2'd0, d); chk("R9 wr ptr", {10'd0, d}, 18'h0);
    hr(2'd3, d); chk("R9 rd ptr", {10'd0, d}, 18'h0);
    hr(2'd2, d); chk("R9 mask", {10'd0, d}, 18'hFF);
  endtask

  task automatic t_write_read();
    logic [7:0] d;
    hw(2'd0, 8'd5);
    put(8'hC1, 8'h3F, 8'hAA, 8'd5);
    hr(2'd0, d); chk("R3 wr ptr after triplet", {10'd0, d}, 18'd6);
    hw(2'd3, 8'd5);
    hr(2'd1, d); chk("R1 R4 red", {10'd0, d}, 18'h01);
    hr(2'd1, d); chk("R1 R4 green", {10'd0, d}, 18'h3F);
    hr(2'd1, d); chk("R1 R4 blue", {10'd0, d}, 18'h2A);
    hr(2'd3, d); chk("R4 rd ptr advanced", {10'd0, d}, 18'd6);
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    hw(2'd0, 8'hFE);
    put(8'h10, 8'h11, 8'h12, 8'hFE);
    put(8'h20, 8'h21, 8'h22, 8'hFF);
    put(8'h30, 8'h31, 8'h32, 8'h00);
    hr(2'd0, d); chk("R3 wrap", {10'd0, d}, 18'd1);
    hw(2'd3, 8'hFF);
    hr(2'd1, d); chk("R2 R4 ff red", {10'd0, d}, {12'd0, model[255][17:12]});
    hr(2'd1, d); chk("R2 R4 ff grn", {10'd0, d}, {12'd0, model[255][11:6]});
    hr(2'd1, d); chk("R2 R4 ff blu", {10'd0, d}, {12'd0, model[255][5:0]});
    hr(2'd1, d); chk("R4 wrap red", {10'd0, d}, {12'd0, model[0][17:12]});
    hr(2'd1, d);
    hr(2'd1, d); chk("R4 wrap blu", {10'd0, d}, {12'd0, model[0][5:0]});
    hr(2'd3, d); chk("R4 rd ptr wrap", {10'd0, d}, 18'd1);
  endtask

  task automatic t_commit();
    logic [17:0] v;
    hw(2'd0, 8'd10);
    put(8'h05, 8'h06, 8'h07, 8'd10);
    hw(2'd0, 8'd10);
    hw(2'd1, 8'h2A); hw(2'd1, 8'h2B);
    look(8'd10, v); chk("R6 staged not visible", v, model[10]);
    hw(2'd1, 8'h2C);
    model[10] = {6'h2A, 6'h2B, 6'h2C};
    look(8'd10, v); chk("R6 visible after blue", v, model[10]);
  endtask

  task automatic t_restart();
    logic [7:0] d;
    hw(2'd0, 8'd20);
    hw(2'd1, 8'h11);
    hw(2'd0, 8'd20);
    put(8'h01, 8'h02, 8'h03, 8'd20);
    hw(2'd3, 8'd20);
    hr(2'd1, d);
    hw(2'd3, 8'd20);
    hr(2'd1, d); chk("R5 restart red", {10'd0, d}, 18'h01);
    hr(2'd1, d); chk("R5 restart grn", {10'd0, d}, 18'h02);
    hr(2'd1, d); chk("R5 restart blu", {10'd0, d}, 18'h03);
  endtask

  task automatic t_mask_latency();
    logic [7:0] d;
    logic [17:0] v;
    hw(2'd2, 8'h0F);
    hr(2'd2, d); chk("R7 mask readback", {10'd0, d}, 18'h0F);
    look(8'hF5, v); chk("R7 masked code", v, model[5]);
    hw(2'd2, 8'hFF);
    look(8'hFF, v); chk("R7 unmasked code", v, model[255]);
    pix_code = 8'd20;
    #1 chk("R8 holds before edge", {pix_red, pix_grn, pix_blu}, model[255]);
    @(negedge clk);
    chk("R8 one edge later", {pix_red, pix_grn, pix_blu}, model[20]);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    host_sel = 2'd0; host_wr = 1'b0; host_rd = 1'b0;
    host_wdata = 8'd0; pix_code = 8'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write_read();
    t_wrap();
    t_commit();
    t_restart();
    t_mask_latency();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule